// File: doc/BRIEF.md
# Keyed Configuration Port Controller

This unit sits on a simple 8-bit I/O bus and exposes two byte addresses: an index port at `BASE_ADDR` and a data port at `BASE_ADDR + 1`. Software first writes a two-byte unlock key to the index port. After that, any other byte written to the index port selects an internal configuration register, and reads and writes on the data port reach that register. A dedicated lock byte written to the index port closes access again.

Registers below 0x30 are global. The unit implements three of them itself: a logical-device selector, a read-only chip identifier, and a per-device activate bit at 0x30. All indices from 0x31 upward belong to the bank of the currently selected logical device. Accesses to them are passed through a request/write-enable/address/data interface to device-side logic, together with the selected device number.

Reads return their byte through a registered port, one cycle after the read strobe. While the unit is locked, both ports read as 0xFF.

Top module: `cfg_port_ctrl`

## Requirements
- R1: After reset the unit is locked, the index register is 0x00, every logical device is inactive (`dev_active_o` is all zero), and reads of either port return 0xFF.
- R2: The unit unlocks only after the unlock byte is written to the index port twice with no other index-port write in between. The unlock byte is 0x87 when `ALT_KEY`=0. Any other index-port byte written in between restarts the sequence.
- R3: While unlocked, writing the lock byte (0xAA when `ALT_KEY`=0) to the index port locks the unit again, and the data port then reads 0xFF.
- R4: With `ALT_KEY`=1 the unlock byte is 0x88 and the lock byte is 0xBB. In this variant 0x87 does not unlock, and 0xAA is taken as an ordinary index byte.
- R5: While locked, data-port writes change no register and raise no device request. The index register reads as and is held at 0x00.
- R6: While unlocked, a read of the index port returns the last index byte written since the unlock, or 0x00 if none was written.
- R7: Index 0x07 is the logical-device selector. It keeps the low log2(`NUM_LD`) bits of the written byte and reads back zero-extended (with the default of 16 devices, writing 0x17 reads back 0x07).
- R8: Index 0x20 reads `CHIP_ID` (default 0x52). Writes to it are ignored.
- R9: Index 0x30 holds the activate bit of the selected device in bit 0. It drives `dev_active_o[selected]` from the clock edge after the write and reads back as 0x00 or 0x01. The activate bits of other devices are unaffected.
- R10: Data-port accesses at index 0x31 and above raise `dev_req_o` in the same cycle, with `dev_we_o` set for writes and `dev_ld_o`, `dev_addr_o` and `dev_wdata_o` valid. For reads, `dev_rdata_i` is returned.
- R11: The other global indices (0x00 to 0x2F, apart from 0x07 and 0x20) read 0x00, ignore writes and raise no device request.
- R12: `io_rvalid_o` pulses for one cycle after each read strobe aimed at one of the two ports, with the read byte on `io_rdata_o` in that cycle.
- R13: Bus cycles at addresses other than the two ports are ignored: they neither advance the key sequence nor produce read data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| io_addr_i | input | ADDR_W | Bus address |
| io_wr_i | input | 1 | Write strobe |
| io_rd_i | input | 1 | Read strobe |
| io_wdata_i | input | 8 | Write data |
| io_rdata_o | output | 8 | Read data, registered |
| io_rvalid_o | output | 1 | Read data valid pulse |
| dev_req_o | output | 1 | Banked register access request |
| dev_we_o | output | 1 | Banked access is a write |
| dev_ld_o | output | log2(NUM_LD) | Selected logical device |
| dev_addr_o | output | 8 | Banked register index |
| dev_wdata_o | output | 8 | Banked write data |
| dev_rdata_i | input | 8 | Banked read data, same cycle |
| dev_active_o | output | NUM_LD | Per-device activate bits |

## Verification
On every cycle, the embedded assertions check the following:
- The unit opens only right after an unlock byte.
- A lock byte always closes it.
- A broken key sequence falls back to locked.
- No device request escapes while locked, and a forwarded request always carries a banked index.
- Locked reads return 0xFF, and chip-identifier reads return the constant.
- Activate bits hold when not written.

The bench scenarios are needed for the rest:
- Register contents surviving a relock.
- The truncation of the device selector.
- Device read data being routed back.
- Global holes reading zero.
- Foreign addresses being ignored.
- The alternate key pair, shown by a second instance on the same bus.

// File: rtl/cfg_port_pkg.sv
package cfg_port_pkg;
  localparam logic [7:0] KEY_OPEN_STD  = 8'h87;
  localparam logic [7:0] KEY_CLOSE_STD = 8'hAA;
  localparam logic [7:0] KEY_OPEN_ALT  = 8'h88;
  localparam logic [7:0] KEY_CLOSE_ALT = 8'hBB;

  localparam logic [7:0] IDX_LDSEL  = 8'h07;
  localparam logic [7:0] IDX_CHIPID = 8'h20;
  localparam logic [7:0] IDX_ACT    = 8'h30;
  localparam logic [7:0] IDX_FWD    = 8'h31;
  localparam logic [7:0] IDLE_BYTE  = 8'hFF;

  typedef enum logic [1:0] {
    LK_LOCKED = 2'd0,
    LK_HALF   = 2'd1,
    LK_OPEN   = 2'd2
  } lock_st_e;
endpackage

// File: rtl/cfg_key_fsm.sv
module cfg_key_fsm
  import cfg_port_pkg::*;
#(
  parameter bit ALT_KEY = 1'b0
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       idx_wr_i,
  input  logic [7:0] wdata_i,
  output logic       unlocked_o,
  output logic       idx_load_o
);
  logic [7:0] key_open, key_close;
  lock_st_e   st_q, st_d;

  if (ALT_KEY) begin : g_alt_key
    assign key_open  = KEY_OPEN_ALT;
    assign key_close = KEY_CLOSE_ALT;
  end else begin : g_std_key
    assign key_open  = KEY_OPEN_STD;
    assign key_close = KEY_CLOSE_STD;
  end

  always_comb begin
    st_d = st_q;
    if (idx_wr_i) begin
      unique case (st_q)
        LK_LOCKED: st_d = (wdata_i == key_open)  ? LK_HALF   : LK_LOCKED;
        LK_HALF:   st_d = (wdata_i == key_open)  ? LK_OPEN   : LK_LOCKED;
        LK_OPEN:   st_d = (wdata_i == key_close) ? LK_LOCKED : LK_OPEN;
        default:   st_d = LK_LOCKED;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= LK_LOCKED;
    else         st_q <= st_d;
  end

  assign unlocked_o = (st_q == LK_OPEN);
  assign idx_load_o = idx_wr_i && (st_q == LK_OPEN) && (wdata_i != key_close);

  AST_OPEN_AFTER_KEY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(unlocked_o) |-> $past(idx_wr_i && wdata_i == key_open)); // R2
  AST_BROKEN_KEY_LOCKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == LK_HALF && idx_wr_i && wdata_i != key_open) |=> !unlocked_o && st_q == LK_LOCKED); // R2
  AST_CLOSE_RELOCKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (unlocked_o && idx_wr_i && wdata_i == key_close) |=> !unlocked_o); // R3
endmodule

// File: rtl/cfg_glb_regs.sv
module cfg_glb_regs
  import cfg_port_pkg::*;
#(
  parameter int unsigned NUM_LD  = 16,
  parameter logic [7:0]  CHIP_ID = 8'h52,
  localparam int unsigned LD_W   = (NUM_LD > 1) ? $clog2(NUM_LD) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [7:0]        index_i,
  input  logic [7:0]        wdata_i,
  output logic [7:0]        rdata_o,
  output logic [LD_W-1:0]   ld_sel_o,
  output logic [NUM_LD-1:0] active_o
);
  logic [LD_W-1:0]   ld_q;
  logic [NUM_LD-1:0] act_q;
  logic              wr_ld, wr_act, act_sel;

  assign wr_ld  = wr_i && (index_i == IDX_LDSEL);
  assign wr_act = wr_i && (index_i == IDX_ACT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    ld_q <= '0;
    else if (wr_ld) ld_q <= wdata_i[LD_W-1:0];
  end

  for (genvar g = 0; g < NUM_LD; g++) begin : g_act
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                             act_q[g] <= 1'b0;
      else if (wr_act && ld_q == LD_W'(g))     act_q[g] <= wdata_i[0];
    end
  end

  assign act_sel = (32'(ld_q) < NUM_LD) ? act_q[ld_q] : 1'b0;

  always_comb begin
    unique case (index_i)
      IDX_LDSEL:  rdata_o = 8'(ld_q);
      IDX_CHIPID: rdata_o = CHIP_ID;
      IDX_ACT:    rdata_o = {7'd0, act_sel};
      default:    rdata_o = 8'h00;
    endcase
  end

  assign ld_sel_o = ld_q;
  assign active_o = act_q;

  AST_ACT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_act |=> $stable(active_o)); // R9
  AST_ACT_SINGLE_CHANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_act |=> $countones(active_o ^ $past(active_o)) <= 1); // R9
endmodule

// File: rtl/cfg_port_ctrl.sv
module cfg_port_ctrl
  import cfg_port_pkg::*;
#(
  parameter int unsigned        ADDR_W    = 16,
  parameter logic [ADDR_W-1:0]  BASE_ADDR = 'h2E,
  parameter int unsigned        NUM_LD    = 16,
  parameter logic [7:0]         CHIP_ID   = 8'h52,
  parameter bit                 ALT_KEY   = 1'b0,
  localparam int unsigned       LD_W      = (NUM_LD > 1) ? $clog2(NUM_LD) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] io_addr_i,
  input  logic              io_wr_i,
  input  logic              io_rd_i,
  input  logic [7:0]        io_wdata_i,
  output logic [7:0]        io_rdata_o,
  output logic              io_rvalid_o,
  output logic              dev_req_o,
  output logic              dev_we_o,
  output logic [LD_W-1:0]   dev_ld_o,
  output logic [7:0]        dev_addr_o,
  output logic [7:0]        dev_wdata_o,
  input  logic [7:0]        dev_rdata_i,
  output logic [NUM_LD-1:0] dev_active_o
);
  localparam logic [ADDR_W-1:0] DATA_ADDR = BASE_ADDR + ADDR_W'(1);

  logic       hit_idx, hit_dat, port_rd;
  logic       unlocked, idx_load;
  logic [7:0] index_q, glb_rdata, rd_byte;
  logic       banked, dat_wr, dat_rd;

  assign hit_idx = (io_addr_i == BASE_ADDR);
  assign hit_dat = (io_addr_i == DATA_ADDR);
  assign port_rd = io_rd_i && (hit_idx || hit_dat);

  cfg_key_fsm #(.ALT_KEY(ALT_KEY)) u_key_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .idx_wr_i   (io_wr_i && hit_idx),
    .wdata_i    (io_wdata_i),
    .unlocked_o (unlocked),
    .idx_load_o (idx_load)
  );

  // index is cleared whenever the port is not open
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       index_q <= 8'h00;
    else if (!unlocked) index_q <= 8'h00;
    else if (idx_load)  index_q <= io_wdata_i;
  end

  assign banked = (index_q >= IDX_FWD);
  assign dat_wr = unlocked && hit_dat && io_wr_i;
  assign dat_rd = unlocked && hit_dat && io_rd_i;

  cfg_glb_regs #(.NUM_LD(NUM_LD), .CHIP_ID(CHIP_ID)) u_glb_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_i     (dat_wr && !banked),
    .index_i  (index_q),
    .wdata_i  (io_wdata_i),
    .rdata_o  (glb_rdata),
    .ld_sel_o (dev_ld_o),
    .active_o (dev_active_o)
  );

  assign dev_req_o   = (dat_wr || dat_rd) && banked;
  assign dev_we_o    = dat_wr && banked;
  assign dev_addr_o  = index_q;
  assign dev_wdata_o = io_wdata_i;

  always_comb begin
    if (!unlocked)    rd_byte = IDLE_BYTE;
    else if (hit_idx) rd_byte = index_q;
    else if (banked)  rd_byte = dev_rdata_i;
    else              rd_byte = glb_rdata;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      io_rvalid_o <= 1'b0;
      io_rdata_o  <= IDLE_BYTE;
    end else begin
      io_rvalid_o <= port_rd;
      if (port_rd) io_rdata_o <= rd_byte;
    end
  end

  AST_LOCKED_NO_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !unlocked |-> !dev_req_o); // R5
  AST_LOCKED_READS_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (io_rvalid_o && !$past(unlocked)) |-> io_rdata_o == 8'hFF); // R1
  AST_REQ_BANKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dev_req_o |-> dev_addr_o >= 8'h31); // R10
  AST_RVALID_FROM_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    io_rvalid_o |-> $past(io_rd_i && (io_addr_i == BASE_ADDR || io_addr_i == DATA_ADDR))); // R12
  AST_CHIP_ID_CONST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (io_rvalid_o && $past(unlocked && io_rd_i && io_addr_i == DATA_ADDR && index_q == 8'h20))
      |-> io_rdata_o == CHIP_ID); // R8
endmodule

// File: tb/cfg_port_ctrl_bench.sv
module cfg_port_ctrl_bench;
  localparam int unsigned ADDR_W = 16;
  localparam logic [15:0] BASE   = 16'h002E;
  localparam logic [15:0] DATA   = 16'h002F;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] io_addr = '0;
  logic        io_wr = 1'b0, io_rd = 1'b0;
  logic [7:0]  io_wdata = '0;
  logic [7:0]  io_rdata, alt_rdata;
  logic        io_rvalid, alt_rvalid;
  logic        dev_req, dev_we, alt_req, alt_we;
  logic [3:0]  dev_ld, alt_ld;
  logic [7:0]  dev_addr, dev_wdata, dev_rdata, alt_addr, alt_wdata;
  logic [15:0] dev_active, alt_active;

  logic [7:0]  dev_mem [16][256];
  int          req_cnt = 0;
  int          n_chk = 0, n_fail = 0;
  bit          done = 1'b0;

  logic [7:0]  exp_q[$];
  logic [7:0]  alt_q[$];
  string       tag_q[$];

  always #10 clk = ~clk;

  cfg_port_ctrl u_cfg_port_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .io_addr_i(io_addr), .io_wr_i(io_wr), .io_rd_i(io_rd),
    .io_wdata_i(io_wdata), .io_rdata_o(io_rdata), .io_rvalid_o(io_rvalid),
    .dev_req_o(dev_req), .dev_we_o(dev_we), .dev_ld_o(dev_ld), .dev_addr_o(dev_addr),
    .dev_wdata_o(dev_wdata), .dev_rdata_i(dev_rdata), .dev_active_o(dev_active)
  );

  cfg_port_ctrl #(.ALT_KEY(1'b1)) u_cfg_port_ctrl_alt (
    .clk_i(clk), .rst_ni(rst_n), .io_addr_i(io_addr), .io_wr_i(io_wr), .io_rd_i(io_rd),
    .io_wdata_i(io_wdata), .io_rdata_o(alt_rdata), .io_rvalid_o(alt_rvalid),
    .dev_req_o(alt_req), .dev_we_o(alt_we), .dev_ld_o(alt_ld), .dev_addr_o(alt_addr),
    .dev_wdata_o(alt_wdata), .dev_rdata_i(8'h00), .dev_active_o(alt_active)
  );

  // device-side bank model
  initial begin
    for (int l = 0; l < 16; l++)
      for (int a = 0; a < 256; a++)
        dev_mem[l][a] = 8'(l * 16) ^ 8'(a);
  end
  assign dev_rdata = dev_mem[dev_ld][dev_addr];
  always @(posedge clk) begin
    if (dev_req) req_cnt <= req_cnt + 1;
    if (dev_req && dev_we) dev_mem[dev_ld][dev_addr] <= dev_wdata;
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic io_write(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    io_addr = a; io_wdata = d; io_wr = 1'b1;
    @(negedge clk);
    io_wr = 1'b0;
  endtask

  task automatic io_read(input logic [15:0] a, input logic [7:0] e, input logic [7:0] ea, input string tag);
    @(negedge clk);
    exp_q.push_back(e); alt_q.push_back(ea); tag_q.push_back(tag);
    io_addr = a; io_rd = 1'b1;
    @(negedge clk);
    io_rd = 1'b0;
  endtask

  // scoreboard monitor
  initial begin
    forever begin
      @(negedge clk);
      if (io_rvalid) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R12 unexpected rvalid", 32'(io_rdata), 32'hx);
        end else begin
          logic [7:0] e, ea;
          string t;
          e = exp_q.pop_front(); ea = alt_q.pop_front(); t = tag_q.pop_front();
          check(io_rdata == e, t, 32'(io_rdata), 32'(e));
          check(alt_rvalid && alt_rdata == ea, {t, " alt"}, 32'(alt_rdata), 32'(ea));
        end
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    check(1'b0, "watchdog expired", 32'd0, 32'd1);
    finish_run();
  end

  initial begin
    int c0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    check(dev_active == 16'h0, "R1 active after reset", 32'(dev_active), 32'h0);
    io_read(BASE, 8'hFF, 8'hFF, "R1 index port locked");
    io_read(DATA, 8'hFF, 8'hFF, "R1 data port locked");

    // R5 locked data write: no request
    c0 = req_cnt;
    io_write(DATA, 8'h55);
    check(req_cnt == c0, "R5 no request while locked", 32'(req_cnt), 32'(c0));

    // R13 keys at a foreign address do nothing
    io_write(BASE + 16'd2, 8'h87);
    io_write(BASE + 16'd2, 8'h87);
    io_read(BASE, 8'hFF, 8'hFF, "R13 foreign key ignored");
    @(negedge clk);
    io_addr = BASE + 16'd5; io_rd = 1'b1;
    @(negedge clk);
    io_rd = 1'b0;
    check(!io_rvalid, "R13 foreign read no rvalid", 32'(io_rvalid), 32'd0);

    // R2 interrupted key
    io_write(BASE, 8'h87);
    io_write(BASE, 8'h11);
    io_write(BASE, 8'h87);
    io_read(DATA, 8'hFF, 8'hFF, "R2 broken key stays locked");
    io_write(BASE, 8'h87);
    io_read(BASE, 8'h00, 8'hFF, "R2 unlocked after two keys, R6 index zero");

    // R6, R8
    io_write(BASE, 8'h20);
    io_read(BASE, 8'h20, 8'hFF, "R6 index readback");
    io_read(DATA, 8'h52, 8'hFF, "R8 chip id");
    io_write(DATA, 8'h00);
    io_read(DATA, 8'h52, 8'hFF, "R8 chip id read-only");

    // R7 selector truncation
    io_write(BASE, 8'h07);
    io_write(DATA, 8'h17);
    io_read(DATA, 8'h07, 8'hFF, "R7 selector truncated");

    // R9 activate bits
    io_write(BASE, 8'h30);
    io_write(DATA, 8'hFF);
    check(dev_active == 16'h0080, "R9 activate dev 7", 32'(dev_active), 32'h0080);
    io_read(DATA, 8'h01, 8'hFF, "R9 activate readback");
    io_write(BASE, 8'h07);
    io_write(DATA, 8'h02);
    io_write(BASE, 8'h30);
    io_read(DATA, 8'h00, 8'hFF, "R9 dev 2 inactive");
    io_write(DATA, 8'h01);
    check(dev_active == 16'h0084, "R9 activate dev 2 keeps dev 7", 32'(dev_active), 32'h0084);

    // R10 banked forwarding
    c0 = req_cnt;
    io_write(BASE, 8'h45);
    io_write(DATA, 8'hA5);
    check(dev_mem[2][8'h45] == 8'hA5, "R10 banked write reached dev 2", 32'(dev_mem[2][8'h45]), 32'hA5);
    io_read(DATA, 8'hA5, 8'hFF, "R10 banked read dev 2");
    io_write(BASE, 8'h07);
    io_write(DATA, 8'h05);
    io_write(BASE, 8'h45);
    io_read(DATA, 8'h15, 8'hFF, "R10 banked read dev 5");
    check(req_cnt == c0 + 3, "R10 request count", 32'(req_cnt), 32'(c0 + 3));

    // R11 global holes
    c0 = req_cnt;
    io_write(BASE, 8'h10);
    io_write(DATA, 8'h33);
    io_read(DATA, 8'h00, 8'hFF, "R11 hole 0x10 reads zero");
    io_write(BASE, 8'h2F);
    io_read(DATA, 8'h00, 8'hFF, "R11 hole 0x2F reads zero");
    check(req_cnt == c0, "R11 no request for globals", 32'(req_cnt), 32'(c0));

    // R3 relock, R5 state retained
    io_write(BASE, 8'hAA);
    io_read(BASE, 8'hFF, 8'hFF, "R3 relocked index port");
    io_read(DATA, 8'hFF, 8'hFF, "R3 relocked data port");
    c0 = req_cnt;
    io_write(DATA, 8'h09);
    check(req_cnt == c0, "R5 locked write no request", 32'(req_cnt), 32'(c0));
    io_write(BASE, 8'h87);
    io_write(BASE, 8'h87);
    io_read(BASE, 8'h00, 8'hFF, "R5 index cleared while locked");
    io_write(BASE, 8'h07);
    io_read(DATA, 8'h05, 8'hFF, "R5 selector kept across lock");
    check(dev_active == 16'h0084, "R5 activate kept across lock", 32'(dev_active), 32'h0084);
    io_write(BASE, 8'hAA);

    // R4 alternate key pair on the second instance
    io_write(BASE, 8'h88);
    io_write(BASE, 8'h88);
    io_write(BASE, 8'h20);
    io_read(DATA, 8'hFF, 8'h52, "R4 alt key opens alt only");
    io_write(BASE, 8'hAA);
    io_read(BASE, 8'hFF, 8'hAA, "R4 0xAA is an index in alt");
    io_write(BASE, 8'hBB);
    io_read(BASE, 8'hFF, 8'hFF, "R4 0xBB locks alt");

    repeat (3) @(negedge clk);
    check(exp_q.size() == 0, "R12 all reads answered", 32'(exp_q.size()), 32'd0);
    finish_run();
  end
endmodule